// File: doc/BRIEF.md
# Counted Streaming Read Unit

This block serves a sequencer core that pulls operands from three streaming sources through a single read port. A read request names a source with a two-bit code. A code of 0 reads the hardwired zero register. A code of 1 fetches a 32-bit word from memory. A code of 2 reads a word from the register file. A code of 3 takes the next word from the packet queue. The memory and register-file streams are each steered by a cursor, which is a count paired with an address. When the count is non-zero, a read consumes one unit of the count and moves the address forward. When the count is zero, a read returns the word at the current address and the cursor stays put. A packet read consumes one word from the queue and lowers a remaining-words counter.

Software sets up the cursors and the remaining counter through a small indexed configuration bus. That bus also reads the registers back combinationally. Only one read is in flight at a time. The unit holds `rd_valid` low until the word is available, which means a memory read waits for the memory response and a packet read waits for a queue word.

Top module: `stream_rd_unit`

## Requirements
- R1: A read with source code 0 returns a word of all zeros in the cycle after the request.
- R2: A read with source code 1 presents the 64-bit cursor address on `mem_req_addr` and holds it, with `mem_req_valid` high, until `mem_req_ready` is seen. The word that arrives with `mem_rsp_valid` is returned on `rd_data` one cycle later, and `rd_valid` stays low before the response arrives.
- R3: A memory read with a non-zero count lowers the count by 1 and adds 4 to the 64-bit address, with a carry from the low word into the high word.
- R4: A read with source code 2 drives `rf_addr` from the register cursor and returns `rf_rdata` in the cycle after the request. With a non-zero count, the count drops by 1 and the address rises by 1, wrapping modulo 2^RF_AW.
- R5: With a count of zero, a memory or register-file read still returns the word at the current address, and both the count and the address stay unchanged.
- R6: Configuration index map: 0 = memory count, 1 = memory address low word, 2 = memory address high word, 3 = register count, 4 = register address, 5 = packet remaining counter. All of them read 0 after reset. Indices 6 and 7 read 0 and ignore writes.
- R7: A read with source code 3 raises `pkt_ready` and waits. It returns the word accepted on `pkt_valid` and lowers the remaining counter by 1.
- R8: While the packet queue is empty, `rd_valid` stays low and the read stalls until a word is offered.
- R9: The remaining counter saturates at zero. A pop at zero pulses `rd_underflow` together with that read's `rd_valid`. A pop above zero leaves `rd_underflow` low.
- R10: A request raised while a read is pending is dropped. It issues no memory request, produces no extra response and moves no cursor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 3 | Configuration register index |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Combinational readback of the indexed register |
| rd_req | input | 1 | Read request, accepted only when idle |
| rd_src | input | 2 | Source code: 0 zero, 1 memory, 2 register file, 3 packet |
| rd_valid | output | 1 | One-cycle pulse marking the returned word |
| rd_data | output | 32 | Returned word |
| rd_underflow | output | 1 | Pulses with a packet read popped at remaining count zero |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory read request accepted |
| mem_req_addr | output | 64 | Memory byte address |
| mem_rsp_valid | input | 1 | Memory read data valid |
| mem_rsp_data | input | 32 | Memory read data |
| rf_addr | output | 8 | Register file read address |
| rf_rdata | input | 32 | Register file read data (combinational) |
| pkt_valid | input | 1 | Packet queue word valid |
| pkt_ready | output | 1 | Unit is waiting for a packet word |
| pkt_data | input | 32 | Packet queue word |

## Verification
The assertions assume that the environment keeps to three rules:
- `mem_rsp_valid` comes only after a request has been accepted.
- `rf_rdata` is a combinational function of `rf_addr`.
- Configuration writes never coincide with a cursor update.

The bench respects all three. It writes the configuration only between reads. It answers the memory from an arithmetic model of the captured address, and only after the handshake. It computes register-file data from `rf_addr` alone. The sweeps walk each cursor across its boundary: the carry from the low address word, and the 8-bit register-address wrap. Each sweep then continues past count zero, and the packet sweep drains the remaining counter into underflow.

// File: rtl/stream_rd_pkg.sv
// Shared encodings for the counted streaming read unit.
// Assumes: two-bit source codes and a three-bit configuration index.
package stream_rd_pkg;

    typedef enum logic [1:0] {
        SRC_ZERO = 2'd0,
        SRC_MEM  = 2'd1,
        SRC_REG  = 2'd2,
        SRC_PKT  = 2'd3
    } rd_src_e;

    typedef enum logic [2:0] {
        CFG_MEM_CNT     = 3'd0,
        CFG_MEM_ADDR_LO = 3'd1,
        CFG_MEM_ADDR_HI = 3'd2,
        CFG_REG_CNT     = 3'd3,
        CFG_REG_ADDR    = 3'd4,
        CFG_PKT_REMAIN  = 3'd5
    } cfg_idx_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MEM_REQ,
        ST_MEM_RSP,
        ST_PKT_WAIT
    } ctl_state_e;

endpackage

// File: rtl/stream_cursor.sv
// Count/address cursor for one stream. When advance is high and the
// count is non-zero, the count drops by one and the address moves by
// STEP. At a count of zero the cursor holds. A configuration write takes
// priority over an advance in the same cycle. The address is written in
// WORD_W-wide slices, one enable per slice.
// Assumes: ADDR_W >= 1, the parent never writes and advances in one cycle.
module stream_cursor #(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 64,
    parameter int WORD_W = 32,
    parameter int STEP   = 4,
    localparam int NWORDS = (ADDR_W + WORD_W - 1) / WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_we,
    input  logic [CNT_W-1:0]  cnt_wdata,
    input  logic [NWORDS-1:0] addr_we,
    input  logic [ADDR_W-1:0] addr_wdata,
    input  logic              advance,
    output logic [CNT_W-1:0]  cnt,
    output logic [ADDR_W-1:0] addr
);

    logic [CNT_W-1:0]  cnt_q, cnt_n;
    logic [ADDR_W-1:0] addr_q, addr_n;

    // Next-state: advance on non-zero count, then apply slice writes.
    always_comb begin
        cnt_n  = cnt_q;
        addr_n = addr_q;
        if (advance && (cnt_q != '0)) begin
            cnt_n  = cnt_q - 1'b1;
            addr_n = addr_q + ADDR_W'(STEP);
        end
        if (cnt_we) begin
            cnt_n = cnt_wdata;
        end
        for (int b = 0; b < ADDR_W; b++) begin
            if (addr_we[b / WORD_W]) begin
                addr_n[b] = addr_wdata[b];
            end
        end
    end

    // Cursor state registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            addr_q <= '0;
        end else begin
            cnt_q  <= cnt_n;
            addr_q <= addr_n;
        end
    end

    assign cnt  = cnt_q;
    assign addr = addr_q;

    AST_CURSOR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && cnt_q != '0 && !cnt_we && addr_we == '0)
        |=> (cnt_q == CNT_W'($past(cnt_q) - 1'b1)) && (addr_q == ADDR_W'($past(addr_q) + ADDR_W'(STEP)))); // R3 R4

    AST_CURSOR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && cnt_q == '0 && !cnt_we && addr_we == '0)
        |=> $stable(cnt_q) && $stable(addr_q)); // R5

endmodule

// File: rtl/pkt_remain_counter.sv
// Remaining-words counter for the packet stream. A pop lowers it by one
// and saturates at zero. A pop at zero produces a one-cycle underflow
// pulse in the following cycle.
// Assumes: configuration writes and pops do not coincide.
module pkt_remain_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CNT_W-1:0] wdata,
    input  logic             pop,
    output logic [CNT_W-1:0] remain,
    output logic             underflow
);

    logic [CNT_W-1:0] remain_q;
    logic             uf_q;

    // Saturating decrement with write priority, plus the underflow pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
            uf_q     <= 1'b0;
        end else begin
            uf_q <= pop && (remain_q == '0);
            if (we) begin
                remain_q <= wdata;
            end else if (pop && (remain_q != '0)) begin
                remain_q <= remain_q - 1'b1;
            end
        end
    end

    assign remain    = remain_q;
    assign underflow = uf_q;

    AST_PKT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && remain_q == '0 && !we) |=> (remain_q == '0) && uf_q); // R9

    AST_PKT_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && remain_q != '0 && !we) |=> (remain_q == CNT_W'($past(remain_q) - 1'b1)) && !uf_q); // R7

endmodule

// File: rtl/stream_rd_unit.sv
// Counted streaming read unit. It accepts one read at a time from four
// sources: zero, memory, register file and packet queue. It moves the
// matching cursor or counter as the read completes and returns the word
// with a one-cycle rd_valid pulse.
// Assumes: rf_rdata is combinational in rf_addr; mem_rsp_valid only follows
// an accepted request; configuration writes are issued between reads.
module stream_rd_unit
    import stream_rd_pkg::*;
#(
    parameter int WORD_W   = 32,
    parameter int CNT_W    = 16,
    parameter int RF_AW    = 8,
    parameter int MEM_STEP = 4,
    parameter int RF_STEP  = 1,
    localparam int MEM_AW  = 2 * WORD_W,
    localparam int IDX_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [WORD_W-1:0] cfg_wdata,
    output logic [WORD_W-1:0] cfg_rdata,
    input  logic              rd_req,
    input  logic [1:0]        rd_src,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_underflow,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [MEM_AW-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [WORD_W-1:0] mem_rsp_data,
    output logic [RF_AW-1:0]  rf_addr,
    input  logic [WORD_W-1:0] rf_rdata,
    input  logic              pkt_valid,
    output logic              pkt_ready,
    input  logic [WORD_W-1:0] pkt_data
);

    ctl_state_e        state_q;
    logic [1:0]        last_src_q;
    logic              rd_valid_q;
    logic [WORD_W-1:0] rd_data_q;

    logic [CNT_W-1:0]  mem_cnt, rf_cnt, pkt_remain;
    logic [MEM_AW-1:0] mem_addr;
    logic [RF_AW-1:0]  rf_cur;
    logic              mem_adv, rf_adv, pkt_pop;
    logic              idle_accept;

    // Decode of the completion events that move each stream's state.
    assign idle_accept = (state_q == ST_IDLE) && rd_req;
    assign mem_adv     = (state_q == ST_MEM_RSP) && mem_rsp_valid;
    assign rf_adv      = idle_accept && (rd_src == SRC_REG);
    assign pkt_pop     = (state_q == ST_PKT_WAIT) && pkt_valid;

    // Memory cursor: 64-bit byte address in two slices, step of MEM_STEP.
    stream_cursor #(
        .CNT_W (CNT_W),
        .ADDR_W(MEM_AW),
        .WORD_W(WORD_W),
        .STEP  (MEM_STEP)
    ) u_mem_cursor (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_we    (cfg_we && (cfg_idx == CFG_MEM_CNT)),
        .cnt_wdata (cfg_wdata[CNT_W-1:0]),
        .addr_we   ({cfg_we && (cfg_idx == CFG_MEM_ADDR_HI),
                     cfg_we && (cfg_idx == CFG_MEM_ADDR_LO)}),
        .addr_wdata({cfg_wdata, cfg_wdata}),
        .advance   (mem_adv),
        .cnt       (mem_cnt),
        .addr      (mem_addr)
    );

    // Register-file cursor: single-slice address, step of RF_STEP.
    stream_cursor #(
        .CNT_W (CNT_W),
        .ADDR_W(RF_AW),
        .WORD_W(WORD_W),
        .STEP  (RF_STEP)
    ) u_rf_cursor (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_we    (cfg_we && (cfg_idx == CFG_REG_CNT)),
        .cnt_wdata (cfg_wdata[CNT_W-1:0]),
        .addr_we   (cfg_we && (cfg_idx == CFG_REG_ADDR)),
        .addr_wdata(cfg_wdata[RF_AW-1:0]),
        .advance   (rf_adv),
        .cnt       (rf_cnt),
        .addr      (rf_cur)
    );

    // Packet remaining-words counter with underflow pulse.
    pkt_remain_counter #(
        .CNT_W(CNT_W)
    ) u_pkt_remain (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we && (cfg_idx == CFG_PKT_REMAIN)),
        .wdata    (cfg_wdata[CNT_W-1:0]),
        .pop      (pkt_pop),
        .remain   (pkt_remain),
        .underflow(rd_underflow)
    );

    // Combinational configuration readback; unmapped indices read zero.
    always_comb begin
        case (cfg_idx)
            CFG_MEM_CNT:     cfg_rdata = WORD_W'(mem_cnt);
            CFG_MEM_ADDR_LO: cfg_rdata = mem_addr[WORD_W-1:0];
            CFG_MEM_ADDR_HI: cfg_rdata = mem_addr[MEM_AW-1:WORD_W];
            CFG_REG_CNT:     cfg_rdata = WORD_W'(rf_cnt);
            CFG_REG_ADDR:    cfg_rdata = WORD_W'(rf_cur);
            CFG_PKT_REMAIN:  cfg_rdata = WORD_W'(pkt_remain);
            default:         cfg_rdata = '0;
        endcase
    end

    // Read sequencer: accept when idle, wait on memory or queue, return word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            last_src_q <= SRC_ZERO;
            rd_valid_q <= 1'b0;
            rd_data_q  <= '0;
        end else begin
            rd_valid_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (rd_req) begin
                        last_src_q <= rd_src;
                        case (rd_src)
                            SRC_ZERO: begin
                                rd_valid_q <= 1'b1;
                                rd_data_q  <= '0;
                            end
                            SRC_REG: begin
                                rd_valid_q <= 1'b1;
                                rd_data_q  <= rf_rdata;
                            end
                            SRC_MEM: state_q <= ST_MEM_REQ;
                            default: state_q <= ST_PKT_WAIT;
                        endcase
                    end
                end
                ST_MEM_REQ: begin
                    if (mem_req_ready) begin
                        state_q <= ST_MEM_RSP;
                    end
                end
                ST_MEM_RSP: begin
                    if (mem_rsp_valid) begin
                        rd_valid_q <= 1'b1;
                        rd_data_q  <= mem_rsp_data;
                        state_q    <= ST_IDLE;
                    end
                end
                default: begin
                    if (pkt_valid) begin
                        rd_valid_q <= 1'b1;
                        rd_data_q  <= pkt_data;
                        state_q    <= ST_IDLE;
                    end
                end
            endcase
        end
    end

    assign rd_valid      = rd_valid_q;
    assign rd_data       = rd_data_q;
    assign mem_req_valid = (state_q == ST_MEM_REQ);
    assign mem_req_addr  = mem_addr;
    assign rf_addr       = rf_cur;
    assign pkt_ready     = (state_q == ST_PKT_WAIT);

    AST_ZERO_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && last_src_q == SRC_ZERO) |-> (rd_data == '0)); // R1

    AST_MEM_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> mem_req_valid && $stable(mem_req_addr)); // R2

    AST_PKT_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_ready && !pkt_valid) |=> !rd_valid && pkt_ready); // R8

    AST_BUSY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_ready && !pkt_valid && rd_req) |=> !mem_req_valid); // R10

    AST_ONE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_req_valid, pkt_ready, rd_valid})); // R10

endmodule

// File: tb/stream_rd_unit_test.sv
module stream_rd_unit_test;
    import stream_rd_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        rd_req = 1'b0;
    logic [1:0]  rd_src = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        rd_underflow;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [63:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic [7:0]  rf_addr;
    logic [31:0] rf_rdata;
    logic        pkt_valid = 1'b0;
    logic        pkt_ready;
    logic [31:0] pkt_data = '0;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [31:0] pkt_word;

    always #2 clk = ~clk;

    assign rf_rdata = {rf_addr, ~rf_addr, rf_addr, 8'hC3};

    stream_rd_unit uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .rd_req(rd_req), .rd_src(rd_src), .rd_valid(rd_valid), .rd_data(rd_data),
        .rd_underflow(rd_underflow),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .rf_addr(rf_addr), .rf_rdata(rf_rdata),
        .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_data(pkt_data)
    );

    function automatic logic [31:0] mem_word(input logic [63:0] a);
        return a[31:0] ^ (a[63:32] * 32'h0000_9E37) ^ 32'h5A5A_0000;
    endfunction

    function automatic logic [31:0] rf_word(input logic [7:0] a);
        return {a, ~a, a, 8'hC3};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    task automatic cfg_write(input logic [2:0] idx, input logic [31:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input logic [2:0] idx, output logic [31:0] val);
        cfg_idx = idx;
        #1;
        val = cfg_rdata;
    endtask

    task automatic do_read(input logic [1:0] src, input int delay, input bit inject,
                           output logic [31:0] data, output logic uf,
                           output logic [63:0] raddr, output bit early, output bit got);
        int  wait_n;
        bit  acc;
        bit  sent;
        acc = 0; sent = 0; got = 0; early = 0; wait_n = delay;
        raddr = '0; data = '0; uf = 1'b0;
        @(negedge clk);
        rd_req = 1'b1; rd_src = src;
        @(negedge clk);
        rd_req = 1'b0;
        for (int n = 0; n < 60 && !got; n++) begin
            mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; pkt_valid = 1'b0; rd_req = 1'b0;
            if (rd_valid) begin
                got = 1; data = rd_data; uf = rd_underflow;
                if (!sent && (src == SRC_MEM || src == SRC_PKT)) early = 1;
            end else begin
                if (inject && n == 0) begin
                    rd_req = 1'b1; rd_src = SRC_MEM;
                end
                if (src == SRC_MEM) begin
                    if (mem_req_valid && !acc) begin
                        mem_req_ready = 1'b1; raddr = mem_req_addr; acc = 1;
                    end else if (acc && !sent) begin
                        if (wait_n == 0) begin
                            mem_rsp_valid = 1'b1; mem_rsp_data = mem_word(raddr); sent = 1;
                        end else begin
                            wait_n--;
                        end
                    end
                end else if (src == SRC_PKT && pkt_ready && !sent) begin
                    if (wait_n == 0) begin
                        pkt_valid = 1'b1; pkt_data = pkt_word; sent = 1;
                    end else begin
                        wait_n--;
                    end
                end
                @(negedge clk);
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        logic [31:0] d;
        logic        uf;
        logic [63:0] ra;
        bit          early;
        bit          got;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R6: reset state and readback of every index
        chk("R6 rd_valid after reset", rd_valid, 0);
        chk("R6 mem_req_valid after reset", mem_req_valid, 0);
        chk("R6 pkt_ready after reset", pkt_ready, 0);
        for (int i = 0; i < 8; i++) begin
            cfg_read(3'(i), v);
            chk("R6 reset readback", v, 0);
        end

        // R6: unmapped indices ignore writes
        cfg_write(3'd6, 32'hDEAD_BEEF);
        cfg_write(3'd7, 32'h1234_5678);
        cfg_read(3'd6, v); chk("R6 index 6 reads zero", v, 0);
        cfg_read(3'd7, v); chk("R6 index 7 reads zero", v, 0);

        // R1: zero source
        for (int k = 0; k < 2; k++) begin
            do_read(SRC_ZERO, 0, 0, d, uf, ra, early, got);
            chk("R1 zero source responds", got, 1);
            chk("R1 zero source data", d, 0);
        end

        // R2 R3 R5: memory sweep across the low-word carry, two high words
        for (int h = 0; h < 2; h++) begin
            logic [63:0] base;
            base = {32'(h), 32'hFFFF_FFF4};
            cfg_write(CFG_MEM_ADDR_LO, base[31:0]);
            cfg_write(CFG_MEM_ADDR_HI, base[63:32]);
            cfg_write(CFG_MEM_CNT, 32'd3);
            cfg_read(CFG_MEM_ADDR_LO, v); chk("R6 mem addr low readback", v, base[31:0]);
            cfg_read(CFG_MEM_ADDR_HI, v); chk("R6 mem addr high readback", v, base[63:32]);
            for (int k = 0; k < 5; k++) begin
                logic [63:0] exp_a;
                logic [63:0] nxt_a;
                int          adv;
                adv   = (k < 3) ? k : 3;
                exp_a = base + 64'(4 * adv);
                nxt_a = base + 64'(4 * ((k + 1 < 3) ? k + 1 : 3));
                do_read(SRC_MEM, k, 0, d, uf, ra, early, got);
                chk("R2 mem read responds", got, 1);
                chk("R2 rd_valid held low before response", early, 0);
                chk("R2 mem request address", ra, exp_a);
                chk("R2 mem read data", d, mem_word(exp_a));
                cfg_read(CFG_MEM_CNT, v);
                chk((k < 3) ? "R3 mem count decrement" : "R5 mem count holds at zero", v, (k < 2) ? 2 - k : 0);
                cfg_read(CFG_MEM_ADDR_LO, v);
                chk((k < 3) ? "R3 mem address low advance" : "R5 mem address low holds", v, nxt_a[31:0]);
                cfg_read(CFG_MEM_ADDR_HI, v);
                chk((k < 3) ? "R3 mem address high carry" : "R5 mem address high holds", v, nxt_a[63:32]);
            end
        end

        // R4 R5: register-file sweep across the address wrap
        cfg_write(CFG_REG_ADDR, 32'd253);
        cfg_write(CFG_REG_CNT, 32'd4);
        for (int k = 0; k < 6; k++) begin
            logic [7:0] exp_a;
            logic [7:0] nxt_a;
            exp_a = 8'(253 + ((k < 4) ? k : 4));
            nxt_a = 8'(253 + ((k + 1 < 4) ? k + 1 : 4));
            do_read(SRC_REG, 0, 0, d, uf, ra, early, got);
            chk("R4 reg read responds", got, 1);
            chk("R4 reg read data", d, rf_word(exp_a));
            cfg_read(CFG_REG_CNT, v);
            chk((k < 4) ? "R4 reg count decrement" : "R5 reg count holds at zero", v, (k < 3) ? 3 - k : 0);
            cfg_read(CFG_REG_ADDR, v);
            chk((k < 4) ? "R4 reg address advance and wrap" : "R5 reg address holds", v, 32'(nxt_a));
        end

        // R7 R8 R9 R10: packet sweep draining into underflow
        cfg_write(CFG_PKT_REMAIN, 32'd3);
        for (int k = 0; k < 5; k++) begin
            pkt_word = 32'hA000_0000 + 32'(k * 7);
            do_read(SRC_PKT, k, (k == 2), d, uf, ra, early, got);
            chk("R7 packet read responds", got, 1);
            chk("R8 rd_valid held low while queue empty", early, 0);
            chk("R7 packet data", d, pkt_word);
            cfg_read(CFG_PKT_REMAIN, v);
            chk((k < 3) ? "R7 remaining decrement" : "R9 remaining saturates", v, (k < 2) ? 2 - k : 0);
            chk("R9 underflow flag", uf, (k >= 3));
            if (k == 2) begin
                for (int c = 0; c < 3; c++) begin
                    @(negedge clk);
                    chk("R10 no extra response", rd_valid, 0);
                    chk("R10 no memory request", mem_req_valid, 0);
                end
                cfg_read(CFG_MEM_CNT, v); chk("R10 memory count untouched", v, 0);
                cfg_read(CFG_MEM_ADDR_LO, v); chk("R10 memory address untouched", v, 32'h0000_0000);
            end
        end

        finish_run();
    end

endmodule